// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Through Cache

This block sits between a 32-bit processor load/store port and a slower main-memory port. It keeps 8 KB of recently used memory as 128 sets of four 16-byte lines. The cache is unified, so instruction and data accesses share the same storage. A read that finds its line returns the stored word. A read that misses fetches the whole line with a four-beat burst and then answers. Every store goes out to memory. When the store's line is present, the cached copy is also patched under the byte enables.

When a line must be placed in a set, the block first looks for an invalid way. If all four ways are valid, it follows a three-bit tree code kept per set. A single flush pulse invalidates every line with one pass over the sets. The same pass runs by itself after reset. Requests wait until the pass is finished.

An address is split as follows: tag is bits [31:11], set index is bits [10:4], word select is bits [3:2], and byte offset is bits [1:0].

Top module: `cache4_sa`

## Requirements
- R1: After reset, `cpu_ack` and `mem_req` are low, and the block spends one cycle per set invalidating all lines before it accepts a request. The first access therefore takes more than 128 cycles and misses.
- R2: A read whose tag matches a valid way in its set raises `cpu_ack` two cycles after acceptance, returns the stored word, and causes no memory traffic.
- R3: A read miss raises `mem_req` with `mem_we`=0 at the line address, which is the request address with bits [3:0] cleared. It takes exactly four `mem_rvalid` beats carrying words 0, 1, 2 and 3 in that order. `cpu_ack` rises after the fourth beat, together with the requested word.
- R4: Every store produces exactly one memory write carrying the request's address, data and byte enables. Bit i of the enable covers data bits [8i+7:8i]. `cpu_ack` comes only after `mem_ack`.
- R5: A store that hits updates the cached word under its byte enables, so a later read hits and returns the merged word.
- R6: A store that misses allocates no line, so a following read of that line misses.
- R7: A fill goes to the lowest-numbered invalid way of the set when one exists. After a flush, four different lines placed in one set all remain resident.
- R8: When all ways are valid, the victim comes from the set's replacement bits B0 (bit 0), B1 (bit 1) and B2 (bit 2):
  - B0=0 with B1=0 selects way 0, and B0=0 with B1=1 selects way 1.
  - B0=1 with B2=0 selects way 2, and B0=1 with B2=1 selects way 3.
  - Every hit or fill on way w sets B0 to the inverse of w's upper bit. It also sets the bit of w's pair (B1 for ways 0 and 1, B2 for ways 2 and 3) to the inverse of w's lower bit.
- R9: A one-cycle `flush` pulse invalidates every line and clears all replacement bits to 0. A request raised during the pass is not acknowledged before the pass ends, at least 128 cycles later, and it misses.
- R10: `mem_req` stays high until the transfer completes, meaning `mem_ack` for a write or the fourth beat for a read. `cpu_ack` is a one-cycle pulse per request. `cpu_req` must be held until `cpu_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pulse: invalidate all lines |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with `cpu_ack` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = single write, 0 = four-beat read |
| mem_addr | output | 32 | Write address or line address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Write completion |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
Corrupted tag, valid or replacement state does not show up as wrong data at first. It shows up in the pattern of memory bursts. An access that should hit starts a fill, or an access that should miss returns in two cycles. Either one is visible on the next access to the affected set. A wrong victim choice only shows when the evicted line is touched again, so the bench tracks the expected resident lines of every set and compares the hit/miss outcome on every access. Corrupted line data shows on the first read of the damaged word, because the cache must always equal memory under write-through.

// File: rtl/cache4_pkg.sv
package cache4_pkg;
  localparam int WAYS = 4;

  typedef logic [1:0] way_t;
  typedef logic [2:0] plru_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_WRITE,
    ST_FLUSH
  } state_t;

  // Tree walk: bit0 chooses the pair, bit1/bit2 choose inside the pair.
  function automatic way_t plru_victim(input plru_t b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  // Point the tree away from the way just used.
  function automatic plru_t plru_touch(input plru_t b, input way_t w);
    plru_t r;
    r    = b;
    r[0] = ~w[1];
    if (w[1]) r[2] = ~w[0];
    else      r[1] = ~w[0];
    return r;
  endfunction
endpackage

// File: rtl/cache4_tag_way.sv
module cache4_tag_way #(
  parameter int TAG_W = 21,
  parameter int SETS  = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic             val_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      val_mem[wr_idx] <= wr_valid;
    end
    rd_tag   <= tag_mem[rd_idx];
    rd_valid <= val_mem[rd_idx];
  end
endmodule

// File: rtl/cache4_data_way.sv
module cache4_data_way #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data
);
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_mem[wr_addr] <= wr_data[b*8 +: 8];
      rd_data[b*8 +: 8] <= lane_mem[rd_addr];
    end
  end
endmodule

// File: rtl/cache4_plru.sv
module cache4_plru #(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      rd_idx,
  output cache4_pkg::plru_t     rd_bits,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  cache4_pkg::plru_t     wr_bits
);
  cache4_pkg::plru_t bits_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) bits_mem[wr_idx] <= wr_bits;
    rd_bits <= bits_mem[rd_idx];
  end
endmodule

// File: rtl/cache4_sa.sv
module cache4_sa
  import cache4_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_ack,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int BE_W   = DATA_W / 8;
  localparam int OFF_W  = $clog2(BE_W);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LOW_W  = OFF_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - IDX_W - LOW_W;
  localparam int DAW    = IDX_W + WSEL_W;

  state_t              state;
  logic                flush_pend;
  logic [IDX_W-1:0]    flush_idx;
  logic [ADDR_W-1:0]   req_addr;
  logic                req_we;
  logic [BE_W-1:0]     req_be;
  logic [DATA_W-1:0]   req_wdata;
  logic [WSEL_W-1:0]   beat;
  way_t                victim_q;
  plru_t               plru_q;

  logic [TAG_W-1:0]    req_tag;
  logic [IDX_W-1:0]    req_idx;
  logic [WSEL_W-1:0]   req_word;
  logic [IDX_W-1:0]    cpu_idx;
  logic [WSEL_W-1:0]   cpu_word;

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[LOW_W +: IDX_W];
  assign req_word = req_addr[OFF_W +: WSEL_W];
  assign cpu_idx  = cpu_addr[LOW_W +: IDX_W];
  assign cpu_word = cpu_addr[OFF_W +: WSEL_W];

  // Array read results and write controls
  logic [TAG_W-1:0]  tag_rd  [WAYS];
  logic              val_rd  [WAYS];
  logic [DATA_W-1:0] dat_rd  [WAYS];
  plru_t             plru_rd;

  logic [WAYS-1:0]   tag_we;
  logic [IDX_W-1:0]  tag_widx;
  logic              tag_wvalid;
  logic [WAYS-1:0]   dat_we;
  logic [DAW-1:0]    dat_waddr;
  logic [BE_W-1:0]   dat_wbe;
  logic [DATA_W-1:0] dat_wdata;
  logic              pl_we;
  logic [IDX_W-1:0]  pl_widx;
  plru_t             pl_wbits;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache4_tag_way #(.TAG_W(TAG_W), .SETS(SETS)) u_tag (
      .clk      (clk),
      .rd_idx   (cpu_idx),
      .rd_tag   (tag_rd[w]),
      .rd_valid (val_rd[w]),
      .wr_en    (tag_we[w]),
      .wr_idx   (tag_widx),
      .wr_tag   (req_tag),
      .wr_valid (tag_wvalid)
    );
    cache4_data_way #(.DATA_W(DATA_W), .DEPTH(SETS*LINE_WORDS)) u_data (
      .clk     (clk),
      .rd_addr ({cpu_idx, cpu_word}),
      .rd_data (dat_rd[w]),
      .wr_en   (dat_we[w]),
      .wr_addr (dat_waddr),
      .wr_be   (dat_wbe),
      .wr_data (dat_wdata)
    );
  end

  cache4_plru #(.SETS(SETS)) u_plru (
    .clk     (clk),
    .rd_idx  (cpu_idx),
    .rd_bits (plru_rd),
    .wr_en   (pl_we),
    .wr_idx  (pl_widx),
    .wr_bits (pl_wbits)
  );

  // Lookup: hit detection and victim selection
  logic [WAYS-1:0] hit_vec;
  logic            hit;
  way_t            hit_way;
  logic            any_inv;
  way_t            inv_way;
  way_t            victim;

  always_comb begin
    hit_vec = '0;
    hit_way = '0;
    any_inv = 1'b0;
    inv_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = val_rd[w] && (tag_rd[w] == req_tag);
      if (hit_vec[w]) hit_way = way_t'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!val_rd[w]) begin
        any_inv = 1'b1;
        inv_way = way_t'(w);
      end
    end
    hit    = |hit_vec;
    victim = any_inv ? inv_way : plru_victim(plru_rd);
  end

  logic last_beat;
  assign last_beat = (state == ST_FILL) && mem_rvalid &&
                     (beat == WSEL_W'(LINE_WORDS - 1));

  always_comb begin
    tag_we     = '0;
    tag_widx   = req_idx;
    tag_wvalid = 1'b1;
    if (state == ST_FLUSH) begin
      tag_we     = '1;
      tag_widx   = flush_idx;
      tag_wvalid = 1'b0;
    end else if (last_beat) begin
      tag_we[victim_q] = 1'b1;
    end

    dat_we    = '0;
    dat_waddr = {req_idx, req_word};
    dat_wbe   = req_be;
    dat_wdata = req_wdata;
    if (state == ST_LOOK && req_we && hit) begin
      dat_we[hit_way] = 1'b1;
    end else if (state == ST_FILL && mem_rvalid) begin
      dat_we[victim_q] = 1'b1;
      dat_waddr        = {req_idx, beat};
      dat_wbe          = '1;
      dat_wdata        = mem_rdata;
    end

    pl_we    = 1'b0;
    pl_widx  = req_idx;
    pl_wbits = plru_touch(plru_rd, hit_way);
    if (state == ST_FLUSH) begin
      pl_we    = 1'b1;
      pl_widx  = flush_idx;
      pl_wbits = '0;
    end else if (state == ST_LOOK && hit) begin
      pl_we = 1'b1;
    end else if (last_beat) begin
      pl_we    = 1'b1;
      pl_wbits = plru_touch(plru_q, victim_q);
    end
  end

  // Control sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      flush_pend <= 1'b1;
      flush_idx  <= '0;
      req_addr   <= '0;
      req_we     <= 1'b0;
      req_be     <= '0;
      req_wdata  <= '0;
      beat       <= '0;
      victim_q   <= '0;
      plru_q     <= '0;
      cpu_ack    <= 1'b0;
      cpu_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
    end else begin
      cpu_ack <= 1'b0;
      if (flush) flush_pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (flush_pend) begin
            state     <= ST_FLUSH;
            flush_idx <= '0;
            if (!flush) flush_pend <= 1'b0;
          end else if (cpu_req && !cpu_ack) begin
            req_addr  <= cpu_addr;
            req_we    <= cpu_we;
            req_be    <= cpu_be;
            req_wdata <= cpu_wdata;
            state     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          plru_q <= plru_rd;
          if (req_we) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= req_addr;
            mem_be    <= req_be;
            mem_wdata <= req_wdata;
            state     <= ST_WRITE;
          end else if (hit) begin
            cpu_rdata <= dat_rd[hit_way];
            cpu_ack   <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            victim_q <= victim;
            beat     <= '0;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {req_addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
            state    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rvalid) begin
            beat <= beat + 1'b1;
            if (beat == req_word) cpu_rdata <= mem_rdata;
            if (last_beat) begin
              mem_req <= 1'b0;
              cpu_ack <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            cpu_ack <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          flush_idx <= flush_idx + 1'b1;
          if (flush_idx == IDX_W'(SETS - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checks beside the logic they guard
  assert_one_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK) |-> $onehot0(hit_vec));

  assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr[LOW_W-1:0] == '0));

  assert_store_after_mem_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && req_we) |-> $past(mem_ack));

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH) |-> (!mem_req && !cpu_ack));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_req) |-> $past(mem_ack || mem_rvalid));
endmodule

// File: tb/sim_cache4_sa.sv
`timescale 1ns/1ps
module sim_cache4_sa;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  cache4_sa u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  int fills = 0, beats = 0, writes = 0;
  int cycles = 0;
  logic [31:0] bmem [16384];
  logic [31:0] exp_addr, exp_wdata, exp_line;
  logic [3:0]  exp_be;

  // Expected resident lines per set
  bit          mv [128][4];
  logic [20:0] mt [128][4];
  logic [2:0]  mp [128];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic void model_flush();
    for (int s = 0; s < 128; s++) begin
      for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
      mp[s] = 3'b000;
    end
  endfunction

  function automatic logic [2:0] tree_after(input logic [2:0] b, input int w);
    logic [2:0] r = b;
    r[0] = (w < 2);
    if (w < 2) r[1] = (w == 0);
    else       r[2] = (w == 2);
    return r;
  endfunction

  // Returns 1 when the access should hit
  function automatic bit model_access(input logic [31:0] a, input bit we);
    int s = int'(a[10:4]);
    int v = -1;
    for (int w = 0; w < 4; w++)
      if (mv[s][w] && mt[s][w] == a[31:11]) v = w;
    if (v >= 0) begin
      mp[s] = tree_after(mp[s], v);
      return 1'b1;
    end
    if (!we) begin
      for (int w = 3; w >= 0; w--) if (!mv[s][w]) v = w;
      if (v < 0) v = mp[s][0] ? (mp[s][2] ? 3 : 2) : (mp[s][1] ? 1 : 0);
      mv[s][v] = 1'b1;
      mt[s][v] = a[31:11];
      mp[s] = tree_after(mp[s], v);
    end
    return 1'b0;
  endfunction

  // Memory side responder
  int rsp_cnt = 0;
  always @(negedge clk) begin
    mem_ack = 1'b0;
    mem_rvalid = 1'b0;
    if (rst || !mem_req) rsp_cnt = 0;
    else begin
      if (rsp_cnt == 0) begin
        if (mem_we) begin
          writes++;
          chk(mem_addr == exp_addr, "R4 write address", mem_addr, exp_addr);
          chk(mem_wdata == exp_wdata, "R4 write data", mem_wdata, exp_wdata);
          chk(mem_be == exp_be, "R4 write enables", {28'd0, mem_be}, {28'd0, exp_be});
        end else begin
          fills++;
          chk(mem_addr == exp_line, "R3 burst line address", mem_addr, exp_line);
        end
      end
      rsp_cnt++;
      if (mem_we) begin
        if (rsp_cnt == 3) mem_ack = 1'b1;
      end else if (rsp_cnt >= 3 && rsp_cnt <= 6) begin
        mem_rvalid = 1'b1;
        mem_rdata  = bmem[mem_addr[15:2] + 14'(rsp_cnt - 3)];
        beats++;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected=<190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  logic [31:0] last_rd;
  int          last_lat;
  bit          last_fill;

  task automatic access(input logic [31:0] a, input bit we, input logic [3:0] be, input logic [31:0] wd);
    int f0 = fills;
    int w0 = writes;
    exp_addr  = a;
    exp_wdata = wd;
    exp_be    = be;
    exp_line  = {a[31:4], 4'h0};
    cpu_addr  = a;
    cpu_we    = we;
    cpu_be    = be;
    cpu_wdata = wd;
    cpu_req   = 1'b1;
    last_lat  = 0;
    do begin
      @(negedge clk);
      last_lat++;
    end while (!cpu_ack && last_lat < 5000);
    chk(cpu_ack, "R10 request acknowledged", {31'd0, cpu_ack}, 32'd1);
    last_rd   = cpu_rdata;
    last_fill = (fills != f0);
    cpu_req   = 1'b0;
    if (we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) bmem[a[15:2]][b*8 +: 8] = wd[b*8 +: 8];
      chk(writes == w0 + 1, "R4 one write per store", writes, w0 + 1);
    end
    @(negedge clk);
    chk(!cpu_ack, "R10 ack is one cycle", {31'd0, cpu_ack}, 32'd0);
  endtask

  // Access with model prediction and data check
  task automatic op(input logic [31:0] a, input bit we, input logic [3:0] be, input logic [31:0] wd);
    bit hit = model_access(a, we);
    access(a, we, be, wd);
    if (we) begin
      chk(!last_fill, "R6 store never fills", {31'd0, last_fill}, 32'd0);
    end else begin
      chk(last_rd == bmem[a[15:2]], "R3 read data", last_rd, bmem[a[15:2]]);
      chk(last_fill == !hit, "R8 hit/miss vs replacement", {31'd0, last_fill}, {31'd0, !hit});
      if (hit) chk(last_lat == 2, "R2 hit latency", last_lat, 2);
    end
  endtask

  task automatic pulse_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_flush();
  endtask

  function automatic logic [31:0] in_set(input int tag, input int set, input int word);
    return {16'd0, 5'(tag), 7'(set), 2'(word), 2'b00};
  endfunction

  initial begin
    logic [31:0] rnd;
    for (int i = 0; i < 16384; i++) bmem[i] = seed_word(i);
    model_flush();
    rnd = $urandom(32'h00C0FFEE);
    repeat (4) @(negedge clk);
    chk(!cpu_ack, "R1 ack low in reset", {31'd0, cpu_ack}, 32'd0);
    chk(!mem_req, "R1 mem_req low in reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;

    // R1: start-up invalidate pass, then a miss
    op(32'h0000_0120, 1'b0, 4'h0, 32'h0);
    chk(last_lat > 128, "R1 start-up pass stalls", last_lat, 129);
    chk(last_fill, "R1 first access misses", {31'd0, last_fill}, 32'd1);

    // R2: hits on the same line
    op(32'h0000_0120, 1'b0, 4'h0, 32'h0);
    chk(!last_fill, "R2 repeat read hits", {31'd0, last_fill}, 32'd0);
    op(32'h0000_012C, 1'b0, 4'h0, 32'h0);
    chk(last_lat == 2, "R2 word 3 hit latency", last_lat, 2);

    // R3: miss on word 1 of a new line
    op(32'h0000_8344, 1'b0, 4'h0, 32'h0);
    chk(beats == 4 * fills, "R3 four beats per burst", beats, 4 * fills);

    // R4/R5: store hit under byte enables, then read merged word
    op(32'h0000_0124, 1'b1, 4'b0101, 32'hA1B2C3D4);
    op(32'h0000_0124, 1'b0, 4'h0, 32'h0);
    chk(!last_fill && last_rd == bmem[16'h0124 >> 2], "R5 merged hit",
        last_rd, bmem[16'h0124 >> 2]);

    // R6: store miss does not allocate
    op(32'h0000_4560, 1'b1, 4'hF, 32'h13572468);
    op(32'h0000_4560, 1'b0, 4'h0, 32'h0);
    chk(last_fill, "R6 read after store miss fills", {31'd0, last_fill}, 32'd1);

    // R9: flush stalls and invalidates
    pulse_flush();
    op(in_set(1, 5, 0), 1'b0, 4'h0, 32'h0);
    chk(last_lat >= 128, "R9 request waits for pass", last_lat, 128);
    chk(last_fill, "R9 line gone after flush", {31'd0, last_fill}, 32'd1);

    // R7: four lines fill invalid ways and all stay
    op(in_set(2, 5, 1), 1'b0, 4'h0, 32'h0);
    op(in_set(3, 5, 2), 1'b0, 4'h0, 32'h0);
    op(in_set(4, 5, 3), 1'b0, 4'h0, 32'h0);
    for (int t = 1; t <= 4; t++) begin
      op(in_set(t, 5, 0), 1'b0, 4'h0, 32'h0);
      chk(!last_fill, "R7 resident after invalid-first fill", {31'd0, last_fill}, 32'd0);
    end

    // R8: tree victims (E replaces A, then A replaces C)
    op(in_set(6, 5, 0), 1'b0, 4'h0, 32'h0);
    chk(last_fill, "R8 fifth line misses", {31'd0, last_fill}, 32'd1);
    op(in_set(2, 5, 0), 1'b0, 4'h0, 32'h0);
    chk(!last_fill, "R8 way1 kept", {31'd0, last_fill}, 32'd0);
    op(in_set(1, 5, 0), 1'b0, 4'h0, 32'h0);
    chk(last_fill, "R8 way0 was victim", {31'd0, last_fill}, 32'd1);
    op(in_set(4, 5, 0), 1'b0, 4'h0, 32'h0);
    chk(!last_fill, "R8 way3 kept", {31'd0, last_fill}, 32'd0);
    op(in_set(3, 5, 0), 1'b0, 4'h0, 32'h0);
    chk(last_fill, "R8 way2 was victim", {31'd0, last_fill}, 32'd1);

    // Random mix over a few crowded sets
    for (int n = 0; n < 700; n++) begin
      int tg = int'($urandom % 6);
      int st = 8 + int'($urandom % 3);
      int wd = int'($urandom % 4);
      bit we = ($urandom % 3) == 0;
      logic [3:0] be = 4'($urandom % 15) + 4'd1;
      if (n % 175 == 174) pulse_flush();
      op(in_set(tg, st, wd), we, be, $urandom);
    end
    chk(beats == 4 * fills, "R3 beat total", beats, 4 * fills);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule